// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the configuration port of a line-interface front end. A host clocks 16-bit frames into it over a three-wire serial link: a serial clock, an active-low frame-enable and a data-in line. A fourth line carries data out. Each frame opens with a direction bit and a 3-bit bank select and ends with a 12-bit payload. A write frame updates one of three configuration registers. A read frame sends the addressed register back on the data-out line during the same frame, in the payload slots.

The three registers are a control word, a transmit filter-corner code and a receive filter-corner code. The control word is split into individual enable and bypass outputs and a 3-bit receive gain code. The block also turns that code into a signed gain in dB. Each corner code is 11 bits wide. The top payload bit of a filter write is a broadcast flag: when it is set, the code lands in both filter registers in the same cycle.

The whole block runs on the falling edge of the serial clock, with no separate system clock. Reset is synchronous and active low.

Top module: `serial_ctrl_bank`

## Requirements
- R1: A frame is the sequence of bits sampled on falling serial-clock edges while `frm_n` is low, sent MSB first. Bit 15 is the direction (0 = write, 1 = read), bits 14:12 are the bank select and bits 11:0 are the payload.
- R2: A write with select 000 stores all 12 payload bits in the control word. The outputs decode it as: bit 11 `tx_on`, bit 10 `rx_on`, bit 9 `loopback`, bit 8 `adc_buf_bypass`, bit 7 `rx_filt_bypass`, bit 6 `tx_atten_6db`, bit 5 `dac_to_driver`, bit 4 `tx_filt_bypass`, bit 3 `driver_bypass`, bits 2:0 `rx_gain_code`.
- R3: A write with select 001 stores payload bits 10:0 as `tx_corner`, and select 010 stores them as `rx_corner`. With payload bit 11 clear, the other filter register is left unchanged.
- R4: A write with select 001 or 010 and payload bit 11 set stores bits 10:0 into both `tx_corner` and `rx_corner` on the same edge.
- R5: A read drives the addressed register on `sdout`, MSB first. The value becomes valid after the fourth falling edge and changes after each of falling edges 5 to 15, so falling edges 5 to 16 see payload bits 11 to 0. A filter register reads back with bit 11 as 0.
- R6: `sdout` is 0 whenever it is not carrying a read payload bit: while idle, during the header, after the last payload bit and throughout a write frame.
- R7: Select values 011 and 100 to 111 are reserved. Writes to them change no register, and reads of them return all zeros.
- R8: A frame in which `frm_n` rises before the 16th falling edge changes no register. Bits clocked in after the 16th edge while `frm_n` stays low are ignored.
- R9: `rx_gain_db` is -6, -3, 0, +3, +6 and +9 for gain codes 0 to 5, and +9 for codes 6 and 7.
- R10: While `rst_n` is low at a falling edge, every register and `sdout` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_n | input | 1 | Frame enable, low for the duration of a frame |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial read data out |
| tx_on | output | 1 | Transmit path enabled (0 = powered down) |
| rx_on | output | 1 | Receive path enabled (0 = powered down) |
| loopback | output | 1 | Analog loopback select |
| adc_buf_bypass | output | 1 | Converter input buffer bypass |
| rx_filt_bypass | output | 1 | Receive filter bypass |
| tx_atten_6db | output | 1 | Transmit 6 dB attenuation |
| dac_to_driver | output | 1 | Route converter output to the line pins |
| tx_filt_bypass | output | 1 | Transmit filter bypass |
| driver_bypass | output | 1 | Line driver bypass |
| rx_gain_code | output | 3 | Raw receive gain code |
| rx_gain_db | output | 5 | Decoded receive gain in dB, signed |
| tx_corner | output | 11 | Transmit filter corner code |
| rx_corner | output | 11 | Receive filter corner code |

## Verification
The last payload edge of a frame is where a register commit and a frame abort compete: whether `frm_n` rises just before or just after the 16th falling edge decides whether the write lands. The bench drives both placements, and also a frame that keeps clocking after the 16th bit. The reference model, updated on every falling edge, judges all three. The broadcast write is the other case where two updates fall on one edge. Both filter registers and their readback are compared in that same cycle against a model that copies the code into both registers.

// File: rtl/scrb_pkg.sv
// Package: shared constants and the control-word layout for the serial
// configuration register bank. Assumes a 3-bit select and 12-bit payload.
package scrb_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 12;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'b000;
    localparam logic [SEL_W-1:0] SEL_TXF  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_RXF  = 3'b010;

    // Control word, MSB first; field order sets the bit positions.
    typedef struct packed {
        logic       tx_on;
        logic       rx_on;
        logic       loopback;
        logic       buf_byp;
        logic       rxf_byp;
        logic       tx_att;
        logic       dac_drv;
        logic       txf_byp;
        logic       drv_byp;
        logic [2:0] gain;
    } ctrl_t;

endpackage

// File: rtl/scrb_frame_rx.sv
// Frame receiver: counts bits on falling sclk edges while frm_n is low,
// captures direction and select, and raises combinational read-load and
// write-commit strobes on the edge that completes the header or frame.
// Assumes the host holds frm_n high for at least one edge between frames.
module scrb_frame_rx #(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 12
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              frm_n,
    input  logic              sdin,
    output logic [$clog2(1+SEL_W+DATA_W+1)-1:0] bit_cnt,
    output logic              rw_q,
    output logic              rd_req,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              shift_en,
    output logic              wr_stb,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_W = 1 + SEL_W + DATA_W;
    localparam int HDR_W   = 1 + SEL_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(HDR_W);

    logic [DATA_W-2:0] shreg;
    logic [SEL_W-1:0]  sel_q;
    logic              active;

    assign active = !frm_n && (bit_cnt < CNT_FULL);

    // Bit counter, input shifter and header capture.
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            sel_q   <= '0;
        end else if (frm_n) begin
            bit_cnt <= '0;
        end else if (active) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[DATA_W-3:0], sdin};
            if (bit_cnt == '0)
                rw_q <= sdin;
            if (bit_cnt == CNT_HDR)
                sel_q <= {shreg[SEL_W-2:0], sdin};
        end
    end

    // Strobes that act on the edge which samples the deciding bit.
    always_comb begin
        rd_req   = active && (bit_cnt == CNT_HDR) && rw_q;
        rd_sel   = {shreg[SEL_W-2:0], sdin};
        shift_en = active && rw_q && (bit_cnt >= CNT_PAY) && (bit_cnt < CNT_LAST);
        wr_stb   = active && (bit_cnt == CNT_LAST) && !rw_q;
        wr_sel   = sel_q;
        wr_data  = {shreg, sdin};
    end

endmodule

// File: rtl/scrb_regs.sv
// Register bank: holds the control word and the two filter-corner codes,
// applies the broadcast flag on filter writes and muxes read data.
// Assumes at most one write strobe per falling edge.
module scrb_regs
    import scrb_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 12
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-2:0] tx_code,
    output logic [DATA_W-2:0] rx_code,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CODE_W = DATA_W - 1;

    logic [CODE_W-1:0] filt_q [2];
    logic              wr_filt;

    assign wr_filt = (wr_sel == SEL_TXF) || (wr_sel == SEL_RXF);

    // Control word register.
    always_ff @(negedge sclk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_stb && wr_sel == SEL_CTRL)
            ctrl_q <= wr_data;
    end

    // One register per filter; broadcast writes hit both.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        localparam logic [SEL_W-1:0] OWN_SEL = (g == 0) ? SEL_TXF : SEL_RXF;
        always_ff @(negedge sclk) begin
            if (!rst_n)
                filt_q[g] <= '0;
            else if (wr_stb && (wr_sel == OWN_SEL || (wr_filt && wr_data[DATA_W-1])))
                filt_q[g] <= wr_data[CODE_W-1:0];
        end
    end

    assign tx_code = filt_q[0];
    assign rx_code = filt_q[1];

    // Read mux; reserved selects return zero.
    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_TXF:  rd_data = {1'b0, filt_q[0]};
            SEL_RXF:  rd_data = {1'b0, filt_q[1]};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/scrb_readback.sv
// Readback shifter: loads the addressed register when a read header
// completes, then presents one payload bit per falling edge on sdout.
// Holds sdout low at every other time.
module scrb_readback #(
    parameter int DATA_W = 12
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    output logic              sdout
);
    logic [DATA_W-2:0] sh;

    // Output bit and remaining-bits shifter.
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            sdout <= 1'b0;
            sh    <= '0;
        end else if (load) begin
            sdout <= load_data[DATA_W-1];
            sh    <= load_data[DATA_W-2:0];
        end else if (shift_en) begin
            sdout <= sh[DATA_W-2];
            sh    <= {sh[DATA_W-3:0], 1'b0};
        end else begin
            sdout <= 1'b0;
        end
    end

endmodule

// File: rtl/scrb_gain_dec.sv
// Gain decoder: maps the receive gain code to a signed dB value in
// fixed steps, saturating at the top code.
module scrb_gain_dec #(
    parameter int CODE_W   = 3,
    parameter int DB_W     = 5,
    parameter int BASE_DB  = -6,
    parameter int STEP_DB  = 3,
    parameter int TOP_CODE = 5
) (
    input  logic [CODE_W-1:0]     code,
    output logic signed [DB_W-1:0] gain_db
);
    int v;

    // Linear map below the top code, flat above it.
    always_comb begin
        if (int'(code) >= TOP_CODE)
            v = BASE_DB + STEP_DB * TOP_CODE;
        else
            v = BASE_DB + STEP_DB * int'(code);
        gain_db = DB_W'(v);
    end

endmodule

// File: rtl/serial_ctrl_bank.sv
// Top: serial configuration register bank. Receives 16-bit frames on the
// falling edge of sclk, writes or reads one of three registers and
// decodes the control word into individual outputs.
// Assumes sclk is free-running while rst_n is applied.
module serial_ctrl_bank
    import scrb_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              frm_n,
    input  logic              sdin,
    output logic              sdout,
    output logic              tx_on,
    output logic              rx_on,
    output logic              loopback,
    output logic              adc_buf_bypass,
    output logic              rx_filt_bypass,
    output logic              tx_atten_6db,
    output logic              dac_to_driver,
    output logic              tx_filt_bypass,
    output logic              driver_bypass,
    output logic [2:0]        rx_gain_code,
    output logic signed [4:0] rx_gain_db,
    output logic [10:0]       tx_corner,
    output logic [10:0]       rx_corner
);
    localparam int FRAME_W = 1 + SEL_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q;
    logic              rd_req;
    logic [SEL_W-1:0]  rd_sel;
    logic              shift_en;
    logic              wr_stb;
    logic [SEL_W-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rd_data;
    ctrl_t             ctrl;

    scrb_frame_rx #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_rx (
        .sclk(sclk), .rst_n(rst_n), .frm_n(frm_n), .sdin(sdin),
        .bit_cnt(bit_cnt), .rw_q(rw_q), .rd_req(rd_req), .rd_sel(rd_sel),
        .shift_en(shift_en), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    scrb_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .sclk(sclk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .ctrl_q(ctrl_word),
        .tx_code(tx_corner), .rx_code(rx_corner), .rd_data(rd_data)
    );

    scrb_readback #(.DATA_W(DATA_W)) u_rb (
        .sclk(sclk), .rst_n(rst_n), .load(rd_req), .load_data(rd_data),
        .shift_en(shift_en), .sdout(sdout)
    );

    scrb_gain_dec #(.CODE_W(3), .DB_W(5)) u_gain (
        .code(ctrl.gain), .gain_db(rx_gain_db)
    );

    // Field split of the control word.
    always_comb begin
        ctrl           = ctrl_t'(ctrl_word);
        tx_on          = ctrl.tx_on;
        rx_on          = ctrl.rx_on;
        loopback       = ctrl.loopback;
        adc_buf_bypass = ctrl.buf_byp;
        rx_filt_bypass = ctrl.rxf_byp;
        tx_atten_6db   = ctrl.tx_att;
        dac_to_driver  = ctrl.dac_drv;
        tx_filt_bypass = ctrl.txf_byp;
        driver_bypass  = ctrl.drv_byp;
        rx_gain_code   = ctrl.gain;
    end

endmodule

// File: rtl/scrb_chk.sv
// Checker: temporal properties of the register bank, bound into the top.
module scrb_chk #(
    parameter int CNT_W = 5
) (
    input logic              sclk,
    input logic              rst_n,
    input logic              frm_n,
    input logic              sdout,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              rw_q,
    input logic              wr_stb,
    input logic [2:0]        wr_sel,
    input logic [11:0]       wr_data,
    input logic [11:0]       ctrl_word,
    input logic [10:0]       tx_corner,
    input logic [10:0]       rx_corner,
    input logic [2:0]        rx_gain_code,
    input logic signed [4:0] rx_gain_db
);
    // R8
    idle_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        frm_n |=> ($stable(ctrl_word) && $stable(tx_corner) && $stable(rx_corner)));

    // R6
    dout_idle_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        frm_n |=> !sdout);

    // R6
    dout_hdr_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (!frm_n && bit_cnt < CNT_W'(3)) |=> !sdout);

    // R6
    dout_write_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (!frm_n && bit_cnt != '0 && !rw_q) |=> !sdout);

    // R4
    both_filt_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (wr_stb && (wr_sel == 3'b001 || wr_sel == 3'b010) && wr_data[11])
        |=> (tx_corner == rx_corner && tx_corner == $past(wr_data[10:0])));

    // R3
    tx_only_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'b001 && !wr_data[11]) |=> $stable(rx_corner));

    // R7
    resv_write_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (wr_stb && wr_sel >= 3'b011)
        |=> ($stable(ctrl_word) && $stable(tx_corner) && $stable(rx_corner)));

    // R9
    gain_top_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (rx_gain_code >= 3'd5) |-> (rx_gain_db == 5'sd9));

    // R9
    gain_range_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (rx_gain_db >= -5'sd6) && (rx_gain_db <= 5'sd9));

endmodule

bind serial_ctrl_bank scrb_chk #(.CNT_W(CNT_W)) u_chk (
    .sclk(sclk), .rst_n(rst_n), .frm_n(frm_n), .sdout(sdout),
    .bit_cnt(bit_cnt), .rw_q(rw_q), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_word(ctrl_word), .tx_corner(tx_corner),
    .rx_corner(rx_corner), .rx_gain_code(rx_gain_code), .rx_gain_db(rx_gain_db)
);

// File: tb/tb_serial_ctrl_bank.sv
// Bench: behavioural reference model updated on every falling edge,
// compared with the design on every rising edge, plus named checks.
module tb_serial_ctrl_bank;
    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_n = 1'b1;
    logic sdin = 1'b0;
    logic sdout, tx_on, rx_on, loopback, adc_buf_bypass, rx_filt_bypass;
    logic tx_atten_6db, dac_to_driver, tx_filt_bypass, driver_bypass;
    logic [2:0] rx_gain_code;
    logic signed [4:0] rx_gain_db;
    logic [10:0] tx_corner, rx_corner;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    always #4 sclk = ~sclk;

    serial_ctrl_bank dut (
        .sclk(sclk), .rst_n(rst_n), .frm_n(frm_n), .sdin(sdin), .sdout(sdout),
        .tx_on(tx_on), .rx_on(rx_on), .loopback(loopback),
        .adc_buf_bypass(adc_buf_bypass), .rx_filt_bypass(rx_filt_bypass),
        .tx_atten_6db(tx_atten_6db), .dac_to_driver(dac_to_driver),
        .tx_filt_bypass(tx_filt_bypass), .driver_bypass(driver_bypass),
        .rx_gain_code(rx_gain_code), .rx_gain_db(rx_gain_db),
        .tx_corner(tx_corner), .rx_corner(rx_corner)
    );

    // Reference model state.
    logic [11:0] m_ctrl = 0;
    logic [10:0] m_tx = 0, m_rx = 0;
    logic        m_dout = 0;
    int          m_cnt = 0;
    bit          m_bits[$];
    bit          m_rw;
    int          m_sel;
    logic [11:0] m_rd;

    function automatic logic [11:0] model_read(int s);
        if (s == 0) return m_ctrl;
        if (s == 1) return {1'b0, m_tx};
        if (s == 2) return {1'b0, m_rx};
        return 12'h000;
    endfunction

    function automatic int exp_db(int code);
        return (code < 5) ? (-6 + 3 * code) : 9;
    endfunction

    always @(negedge sclk) begin
        if (!rst_n) begin
            started = 1;
            m_ctrl = 0; m_tx = 0; m_rx = 0; m_dout = 0; m_cnt = 0;
            m_bits.delete();
        end else if (frm_n) begin
            m_cnt = 0; m_bits.delete(); m_dout = 0;
        end else if (m_cnt < 16) begin
            m_bits.push_back(sdin);
            m_cnt++;
            if (m_cnt == 4) begin
                m_rw  = m_bits[0];
                m_sel = 4 * m_bits[1] + 2 * m_bits[2] + m_bits[3];
                m_rd  = model_read(m_sel);
                m_dout = m_rw ? m_rd[11] : 1'b0;
            end else if (m_cnt > 4 && m_cnt < 16) begin
                m_dout = m_rw ? m_rd[15 - m_cnt] : 1'b0;
            end else begin
                m_dout = 0;
            end
            if (m_cnt == 16 && !m_rw) begin
                logic [11:0] w;
                for (int k = 0; k < 12; k++) w[11 - k] = m_bits[4 + k];
                if (m_sel == 0) m_ctrl = w;
                else if (m_sel == 1 || m_sel == 2) begin
                    if (m_sel == 1 || w[11]) m_tx = w[10:0];
                    if (m_sel == 2 || w[11]) m_rx = w[10:0];
                end
            end
        end else begin
            m_dout = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output on every rising edge.
    always @(posedge sclk) begin
        if (started && !done) begin
            chk(sdout === m_dout, "R5/R6", "sdout", int'(sdout), int'(m_dout));
            chk({tx_on, rx_on, loopback, adc_buf_bypass, rx_filt_bypass, tx_atten_6db,
                 dac_to_driver, tx_filt_bypass, driver_bypass, rx_gain_code} === m_ctrl,
                "R2", "control fields",
                int'({tx_on, rx_on, loopback, adc_buf_bypass, rx_filt_bypass, tx_atten_6db,
                      dac_to_driver, tx_filt_bypass, driver_bypass, rx_gain_code}),
                int'(m_ctrl));
            chk(tx_corner === m_tx, "R3", "tx_corner", int'(tx_corner), int'(m_tx));
            chk(rx_corner === m_rx, "R3", "rx_corner", int'(rx_corner), int'(m_rx));
            chk(int'(rx_gain_db) == exp_db(int'(m_ctrl[2:0])), "R9", "rx_gain_db",
                int'(rx_gain_db), exp_db(int'(m_ctrl[2:0])));
        end
    end

    // Drive one frame of nbits bits; bits past 16 toggle. Returns readback.
    task automatic frame(input bit rw, input logic [2:0] sel, input logic [11:0] d,
                         input int nbits, output logic [11:0] rd);
        logic [15:0] w = {rw, sel, d};
        rd = '0;
        frm_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 16) ? w[15 - i] : i[0];
            @(posedge sclk);
            if (i >= 3 && i <= 14) rd[14 - i] = sdout;
        end
        frm_n = 1'b1;
        sdin  = 1'b0;
        @(posedge sclk);
        @(posedge sclk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [11:0] d);
        logic [11:0] dummy;
        frame(1'b0, sel, d, 16, dummy);
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [11:0] exp, input string req);
        logic [11:0] got;
        frame(1'b1, sel, 12'h000, 16, got);
        chk(got === exp, req, "readback", int'(got), int'(exp));
    endtask

    initial begin
        logic [11:0] junk;
        repeat (4) @(posedge sclk);
        // R10: reset state
        chk({tx_corner, rx_corner} === 22'd0 && !tx_on && !rx_on && !sdout,
            "R10", "reset state", int'({tx_corner, rx_corner}), 0);
        rst_n = 1'b1;
        @(posedge sclk);

        // R1 R2: control write and read
        wr(3'b000, 12'hA5C);
        chk(tx_on && !rx_on && loopback && rx_gain_code == 3'd4, "R2", "ctrl decode",
            int'(rx_gain_code), 4);
        rd_chk(3'b000, 12'hA5C, "R1");

        // R9: gain sweep
        for (int c = 0; c < 8; c++) begin
            wr(3'b000, 12'h600 | 12'(c));
            chk(int'(rx_gain_db) == exp_db(c), "R9", "gain code", int'(rx_gain_db), exp_db(c));
        end

        // R3: single filter writes
        wr(3'b001, 12'h123);
        chk(tx_corner == 11'h123 && rx_corner == 11'h000, "R3", "tx only",
            int'(rx_corner), 0);
        wr(3'b010, 12'h7FF);
        chk(tx_corner == 11'h123 && rx_corner == 11'h7FF, "R3", "rx only",
            int'(tx_corner), 'h123);

        // R4: broadcast from each filter select
        wr(3'b001, 12'h8AB);
        chk(tx_corner == 11'h0AB && rx_corner == 11'h0AB, "R4", "both via tx",
            int'(rx_corner), 'h0AB);
        rd_chk(3'b010, 12'h0AB, "R5");
        wr(3'b010, 12'hF55);
        chk(tx_corner == 11'h755 && rx_corner == 11'h755, "R4", "both via rx",
            int'(tx_corner), 'h755);
        rd_chk(3'b001, 12'h755, "R5");

        // R7: reserved selects
        wr(3'b011, 12'hFFF);
        wr(3'b101, 12'h8FF);
        chk(tx_corner == 11'h755 && rx_corner == 11'h755, "R7", "reserved write",
            int'(tx_corner), 'h755);
        rd_chk(3'b011, 12'h000, "R7");
        rd_chk(3'b111, 12'h000, "R7");

        // R8: abort just before the last edge, early abort, overlong frame
        frame(1'b0, 3'b001, 12'h811, 15, junk);
        chk(tx_corner == 11'h755, "R8", "abort at 15 bits", int'(tx_corner), 'h755);
        frame(1'b0, 3'b000, 12'hFFF, 7, junk);
        rd_chk(3'b000, 12'h607, "R8");
        frame(1'b0, 3'b010, 12'h222, 21, junk);
        chk(rx_corner == 11'h222 && tx_corner == 11'h755, "R8", "bits after 16 ignored",
            int'(rx_corner), 'h222);

        // R10: reset after activity
        rst_n = 1'b0;
        repeat (2) @(posedge sclk);
        chk(tx_corner == 0 && rx_corner == 0 && rx_gain_code == 0, "R10", "reset again",
            int'(rx_corner), 0);
        rst_n = 1'b1;
        rd_chk(3'b000, 12'h000, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule